// File: doc/BRIEF.md
# Daisy-Chained Interrupt Priority Controller

This block is the interrupt logic of a serial peripheral with several internal interrupt sources that sits in an external priority daisy chain. The sources are ranked by a fixed priority: index 0 is highest. With the default of four sources the order is channel-A receive (0), channel-B receive (1), channel-A transmit (2) and channel-B transmit (3). Each source has three bits: an enable, a pending flag and an in-service flag. A single master enable gates every source at once.

A source that is pending and enabled requests service by pulling the active-low request line. It does so only when the chain input is high and nothing of equal or higher priority is in service. An acknowledge can come from a hardware strobe or from a software command. The acknowledge marks the winning source as in service, clears its pending flag and drives its vector code for that cycle.

While any source is in service, all lower-priority internal sources are held off and the chain output is low, which holds off the peripherals further down the chain. An end-of-service command clears the in-service bit of highest priority, which reopens the chain below it.

Top module: `irq_daisy_ctrl`

## Requirements
- R1: A source's pending bit is set on the clock edge after an event only if that source's enable bit was 1 at the event. An event on a disabled source leaves the pending bits, read on `pendBits` (bit i = source i), unchanged.
- R2: While the master enable is 0, `intN` stays high and an acknowledge produces no vector and changes no pending bit.
- R3: `intN` is low exactly when `iei` is high, the master enable is 1, and some source is both pending and enabled with no in-service bit set at its own or any higher priority (a lower index).
- R4: An acknowledge (`ackHw` or `ackSw`, which have the same effect) sets the in-service bit of the single requesting winner and clears its pending bit at the next edge. With `iei` low or no requester, an acknowledge has no effect.
- R5: While any in-service bit is set, `ieo` is low and sources of lower priority cannot request.
- R6: In a cycle where an acknowledge finds a winner with index i, `vecValid` is 1 and `vecOut` = VEC_BASE + i (default 0x40 + i). Otherwise `vecValid` is 0 and `vecOut` is 0.
- R7: `eoiCmd` clears only the in-service bit with the lowest index that is set, at the next edge.
- R8: `ieo` equals `iei` when no in-service bit is set and no source is pending with its enable and the master enable set. `ieo` is low whenever `iei` is low.
- R9: When `wrEn` is high, `wrData[N-1:0]` loads the source enables and `wrData[N]` loads the master enable. Reset clears all enables, pending bits and in-service bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcEvent | input | N | Per-source interrupt event, one cycle per event |
| wrEn | input | 1 | Write strobe for the enable register |
| wrData | input | N+1 | Source enables in bits N-1:0, master enable in bit N |
| iei | input | 1 | Chain input, high when no upstream device is requesting or being served |
| ieo | output | 1 | Chain output to the downstream device |
| intN | output | 1 | Active-low interrupt request |
| ackHw | input | 1 | Hardware acknowledge strobe |
| ackSw | input | 1 | Software acknowledge command |
| eoiCmd | input | 1 | End-of-service: clear the in-service bit of highest priority |
| vecValid | output | 1 | Vector is being driven this cycle |
| vecOut | output | VEC_W | Vector of the acknowledged source |
| pendBits | output | N | Pending bits, read-only status |

## Verification
The main function is exercised with one pending source, then with a higher-priority source arriving while a lower one is in service, and then with a lower source waiting behind an in-service one. These three cases separate correct nesting from plain first-come service. Acknowledges are sent with `iei` low, with the master enable cleared and with nothing pending. This shows that the chain input and the enables gate the winner. End-of-service commands are sent with two nested in-service bits to show that only the higher one is cleared. A partial enable mask is applied to a burst on all sources to show which events are dropped.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef struct packed {
    logic ackFire;
    logic eoiFire;
    logic wrFire;
  } irqStrobe_t;
endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
(
  input  logic       ackHw,
  input  logic       ackSw,
  input  logic       eoiCmd,
  input  logic       wrEn,
  input  logic       anyGrant,
  output irqStrobe_t strb
);
  // Hardware strobe and software command merge into one acknowledge.
  // It only fires when the chain has a winner.
  always_comb begin
    strb.ackFire = (ackHw | ackSw) & anyGrant;
    strb.eoiFire = eoiCmd;
    strb.wrFire  = wrEn;
  end
endmodule

// File: rtl/irqc_path.sv
module irqc_path
  import irqc_pkg::*;
#(
  parameter int N = 4,
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = 8'h40
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N-1:0]     srcEvent,
  input  logic [N:0]       wrData,
  input  logic             iei,
  input  irqStrobe_t       strb,
  output logic [N-1:0]     pendBits,
  output logic [N-1:0]     iusBits,
  output logic [N-1:0]     ieBits,
  output logic             mieBit,
  output logic             anyGrant,
  output logic             ieo,
  output logic             intN,
  output logic             vecValid,
  output logic [VEC_W-1:0] vecOut
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0] ieQ, pendQ, iusQ;
  logic         mieQ;
  logic [N-1:0] activeV, grantV, eoiV;
  logic [N:0]   chainV;
  logic [IDX_W-1:0] winIdx;

  assign chainV[0] = iei;

  // Internal chain: a source passes the chain on only when it is neither
  // in service nor requesting.
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign activeV[i]   = pendQ[i] & ieQ[i] & mieQ;
    assign grantV[i]    = activeV[i] & chainV[i] & ~iusQ[i];
    assign chainV[i+1]  = chainV[i] & ~iusQ[i] & ~activeV[i];
  end

  // Isolate the lowest set index, which is the highest-priority in-service bit.
  assign eoiV = iusQ & (~iusQ + N'(1));

  always_comb begin
    winIdx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (grantV[i]) winIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ieQ   <= '0;
      mieQ  <= 1'b0;
      pendQ <= '0;
      iusQ  <= '0;
    end else begin
      if (strb.wrFire) begin
        ieQ  <= wrData[N-1:0];
        mieQ <= wrData[N];
      end
      pendQ <= (pendQ & ~(strb.ackFire ? grantV : '0)) | (srcEvent & ieQ);
      iusQ  <= (iusQ & ~(strb.eoiFire ? eoiV : '0)) | (strb.ackFire ? grantV : '0);
    end
  end

  assign anyGrant = |grantV;
  assign intN     = ~anyGrant;
  assign ieo      = chainV[N];
  assign vecValid = strb.ackFire;
  assign vecOut   = strb.ackFire ? (VEC_BASE + VEC_W'(winIdx)) : '0;
  assign pendBits = pendQ;
  assign iusBits  = iusQ;
  assign ieBits   = ieQ;
  assign mieBit   = mieQ;
endmodule

// File: rtl/irq_daisy_ctrl.sv
module irq_daisy_ctrl #(
  parameter int N = 4,
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = 8'h40
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N-1:0]     srcEvent,
  input  logic             wrEn,
  input  logic [N:0]       wrData,
  input  logic             iei,
  output logic             ieo,
  output logic             intN,
  input  logic             ackHw,
  input  logic             ackSw,
  input  logic             eoiCmd,
  output logic             vecValid,
  output logic [VEC_W-1:0] vecOut,
  output logic [N-1:0]     pendBits
);
  irqc_pkg::irqStrobe_t strb;
  logic         anyGrant;
  logic [N-1:0] iusBits, ieBits;
  logic         mieBit;

  irqc_ctrl u_ctrl (
    .ackHw(ackHw), .ackSw(ackSw), .eoiCmd(eoiCmd), .wrEn(wrEn),
    .anyGrant(anyGrant), .strb(strb)
  );

  irqc_path #(.N(N), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_path (
    .clk(clk), .rstN(rstN), .srcEvent(srcEvent), .wrData(wrData), .iei(iei),
    .strb(strb), .pendBits(pendBits), .iusBits(iusBits), .ieBits(ieBits),
    .mieBit(mieBit), .anyGrant(anyGrant), .ieo(ieo), .intN(intN),
    .vecValid(vecValid), .vecOut(vecOut)
  );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rstN,
  input logic         iei,
  input logic         ieo,
  input logic         intN,
  input logic         ackHw,
  input logic         ackSw,
  input logic         eoiCmd,
  input logic         vecValid,
  input logic [N-1:0] pendBits,
  input logic [N-1:0] iusBits,
  input logic [N-1:0] ieBits,
  input logic         mieBit
);
  AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((pendBits & ~$past(pendBits) & ~$past(ieBits)) == '0)); // R1
  AST_MIE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !mieBit |-> intN); // R2
  AST_INT_QUALIFIED: assert property (@(posedge clk) disable iff (!rstN)
    !intN |-> (iei && mieBit && ((pendBits & ieBits) != '0))); // R3
  AST_ONE_SERVICE_PER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    (ackHw || ackSw) |=> ($countones(iusBits & ~$past(iusBits)) <= 1)); // R4
  AST_NO_SERVICE_WITHOUT_ACK: assert property (@(posedge clk) disable iff (!rstN)
    !(ackHw || ackSw) |=> ((iusBits & ~$past(iusBits)) == '0)); // R4
  AST_SERVICE_BLOCKS_CHAIN: assert property (@(posedge clk) disable iff (!rstN)
    (iusBits != '0) |-> !ieo); // R5
  AST_VEC_ONLY_ON_ACK: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> ((ackHw || ackSw) && !intN)); // R6
  AST_EOI_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    eoiCmd |=> ($countones($past(iusBits) & ~iusBits) <= 1)); // R7
  AST_IEO_FOLLOWS_IEI: assert property (@(posedge clk) disable iff (!rstN)
    ((iusBits == '0) && (!mieBit || ((pendBits & ieBits) == '0))) |-> (ieo == iei)); // R8
  AST_IEO_LOW_UPSTREAM: assert property (@(posedge clk) disable iff (!rstN)
    !iei |-> !ieo); // R8
endmodule

bind irq_daisy_ctrl irqc_checker #(.N(N)) u_chk (
  .clk(clk), .rstN(rstN), .iei(iei), .ieo(ieo), .intN(intN),
  .ackHw(ackHw), .ackSw(ackSw), .eoiCmd(eoiCmd), .vecValid(vecValid),
  .pendBits(pendBits), .iusBits(iusBits), .ieBits(ieBits), .mieBit(mieBit)
);

// File: tb/irq_daisy_ctrl_test.sv
module irq_daisy_ctrl_test;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] srcEvent = '0;
  logic wrEn = 1'b0;
  logic [N:0] wrData = '0;
  logic iei = 1'b1;
  logic ackHw = 1'b0, ackSw = 1'b0, eoiCmd = 1'b0;
  logic ieo, intN, vecValid;
  logic [7:0] vecOut;
  logic [N-1:0] pendBits;

  always #10 clk = ~clk;

  irq_daisy_ctrl uut (
    .clk(clk), .rstN(rstN), .srcEvent(srcEvent), .wrEn(wrEn), .wrData(wrData),
    .iei(iei), .ieo(ieo), .intN(intN), .ackHw(ackHw), .ackSw(ackSw),
    .eoiCmd(eoiCmd), .vecValid(vecValid), .vecOut(vecOut), .pendBits(pendBits)
  );

  typedef struct {
    string      req;
    logic [N-1:0] pend;
    logic       intN;
    logic       ieo;
    logic       vv;
    logic [7:0] vec;
  } expItem_t;

  expItem_t expQ[$];
  event sampleEv;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // Monitor: pop the expected item and compare with the outputs.
  always @(sampleEv) begin
    expItem_t e;
    e = expQ.pop_front();
    checks++;
    if (pendBits !== e.pend || intN !== e.intN || ieo !== e.ieo ||
        vecValid !== e.vv || vecOut !== e.vec) begin
      fails++;
      $display("FAIL %s: pend=%b intN=%b ieo=%b vv=%b vec=%h expected pend=%b intN=%b ieo=%b vv=%b vec=%h",
               e.req, pendBits, intN, ieo, vecValid, vecOut,
               e.pend, e.intN, e.ieo, e.vv, e.vec);
    end
  end

  // Driver: apply inputs for one cycle and queue the outputs expected before the edge.
  task automatic cyc(input logic [N-1:0] ev, input logic we, input logic [N:0] wd,
                     input logic ieiV, input logic hw, input logic sw, input logic eoi,
                     input logic [N-1:0] ePend, input logic eInt, input logic eIeo,
                     input logic eVv, input logic [7:0] eVec, input string req);
    expItem_t e;
    @(negedge clk);
    srcEvent = ev; wrEn = we; wrData = wd; iei = ieiV;
    ackHw = hw; ackSw = sw; eoiCmd = eoi;
    #2;
    e.req = req; e.pend = ePend; e.intN = eInt; e.ieo = eIeo; e.vv = eVv; e.vec = eVec;
    expQ.push_back(e);
    -> sampleEv;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    //   ev     we  wd        iei hw sw eoi  pend    int ieo vv vec
    cyc(4'b0000,0,5'b00000, 1, 0, 0, 0, 4'b0000, 1, 1, 0, 8'h00, "R9 reset state");
    cyc(4'b1111,0,5'b00000, 1, 0, 0, 0, 4'b0000, 1, 1, 0, 8'h00, "R1 events while disabled");
    cyc(4'b0000,0,5'b00000, 1, 0, 0, 0, 4'b0000, 1, 1, 0, 8'h00, "R1 disabled events dropped");
    cyc(4'b0000,1,5'b01111, 1, 0, 0, 0, 4'b0000, 1, 1, 0, 8'h00, "R9 write enables, master off");
    cyc(4'b0100,0,5'b00000, 1, 0, 0, 0, 4'b0000, 1, 1, 0, 8'h00, "R1 event on txA");
    cyc(4'b0000,0,5'b00000, 1, 1, 0, 0, 4'b0100, 1, 1, 0, 8'h00, "R2 master off blocks request and ack");
    cyc(4'b0000,1,5'b11111, 1, 0, 0, 0, 4'b0100, 1, 1, 0, 8'h00, "R2 pending kept, master on");
    cyc(4'b0000,0,5'b00000, 1, 0, 0, 0, 4'b0100, 0, 0, 0, 8'h00, "R3 request with iei high");
    cyc(4'b0000,0,5'b00000, 0, 0, 0, 0, 4'b0100, 1, 0, 0, 8'h00, "R3 R8 iei low");
    cyc(4'b0000,0,5'b00000, 0, 1, 0, 0, 4'b0100, 1, 0, 0, 8'h00, "R4 ack with iei low ignored");
    cyc(4'b0000,0,5'b00000, 1, 0, 1, 0, 4'b0100, 0, 0, 1, 8'h42, "R4 R6 software ack txA");
    cyc(4'b0000,0,5'b00000, 1, 0, 0, 0, 4'b0000, 1, 0, 0, 8'h00, "R5 in service holds ieo low");
    cyc(4'b1000,0,5'b00000, 1, 0, 0, 0, 4'b0000, 1, 0, 0, 8'h00, "R5 event on txB");
    cyc(4'b0000,0,5'b00000, 1, 0, 0, 0, 4'b1000, 1, 0, 0, 8'h00, "R5 lower source blocked");
    cyc(4'b0001,0,5'b00000, 1, 0, 0, 0, 4'b1000, 1, 0, 0, 8'h00, "R3 event on rxA");
    cyc(4'b0000,0,5'b00000, 1, 0, 0, 0, 4'b1001, 0, 0, 0, 8'h00, "R3 higher source nests");
    cyc(4'b0000,0,5'b00000, 1, 1, 0, 0, 4'b1001, 0, 0, 1, 8'h40, "R4 R6 hardware ack rxA");
    cyc(4'b0000,0,5'b00000, 1, 0, 0, 0, 4'b1000, 1, 0, 0, 8'h00, "R4 rxA pending cleared");
    cyc(4'b0000,0,5'b00000, 1, 0, 0, 1, 4'b1000, 1, 0, 0, 8'h00, "R7 end of service");
    cyc(4'b0000,0,5'b00000, 1, 0, 0, 0, 4'b1000, 1, 0, 0, 8'h00, "R7 only rxA released");
    cyc(4'b0000,0,5'b00000, 1, 0, 0, 1, 4'b1000, 1, 0, 0, 8'h00, "R7 second end of service");
    cyc(4'b0000,0,5'b00000, 1, 0, 0, 0, 4'b1000, 0, 0, 0, 8'h00, "R7 txB now requests");
    cyc(4'b0000,0,5'b00000, 1, 1, 0, 0, 4'b1000, 0, 0, 1, 8'h43, "R6 vector txB");
    cyc(4'b0000,0,5'b00000, 1, 0, 0, 1, 4'b0000, 1, 0, 0, 8'h00, "R5 txB in service");
    cyc(4'b0000,0,5'b00000, 1, 0, 0, 0, 4'b0000, 1, 1, 0, 8'h00, "R8 ieo follows iei when idle");
    cyc(4'b0000,1,5'b10101, 1, 0, 0, 0, 4'b0000, 1, 1, 0, 8'h00, "R9 partial enable mask");
    cyc(4'b1111,0,5'b00000, 1, 0, 0, 0, 4'b0000, 1, 1, 0, 8'h00, "R1 burst on all sources");
    cyc(4'b0000,0,5'b00000, 1, 0, 0, 0, 4'b0101, 0, 0, 0, 8'h00, "R1 only enabled sources pend");
    cyc(4'b0000,0,5'b00000, 1, 1, 0, 0, 4'b0101, 0, 0, 1, 8'h40, "R6 vector rxA first");
    cyc(4'b0000,0,5'b00000, 1, 0, 0, 1, 4'b0100, 1, 0, 0, 8'h00, "R5 txA waits behind rxA");
    cyc(4'b0000,0,5'b00000, 1, 0, 1, 0, 4'b0100, 0, 0, 1, 8'h42, "R4 software ack txA");
    cyc(4'b0000,0,5'b00000, 1, 0, 0, 1, 4'b0000, 1, 0, 0, 8'h00, "R5 txA in service");
    cyc(4'b0000,0,5'b00000, 1, 0, 0, 0, 4'b0000, 1, 1, 0, 8'h00, "R8 chain open again");
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule